// File: doc/BRIEF.md
# Accumulator ALU with Zero/Compare Flag

This block is the arithmetic and compare stage of a small accumulator machine. Each cycle it receives the accumulator, one operand and the current value of the selected register, along with a four-bit operation code. It returns, in the same cycle, the new accumulator value, the new register value, and a proposed flag value with its write enable. The operand is either a register value or an immediate constant that the decoder has already sign-extended.

The single-bit flag F is held in a register inside the block. F serves two purposes. The compare operations write their true/false result into it. Add, sub, increment and decrement write a zero indication into it. All other operations leave it untouched. Arithmetic is modulo 2^W and produces no carry or overflow. Compares treat both values as unsigned.

Top module: `acc_alu_flag`

## Requirements
- R1: Op codes ADD=1, SUB=2, AND=3, OR=4 and XOR=5 drive `acc_o` with acc op operand, taken modulo 256. `reg_o` equals `reg_i`.
- R2: Op code NOT=6 drives `acc_o` with the bitwise complement of `acc_i`. `reg_o` equals `reg_i`.
- R3: Op codes EQ=9, LT=10, LE=11, GT=12 and GE=13 compare `acc_i` (left) against `opnd_i` (right) as unsigned values. They set `flag_nx_o` to 1 when the relation holds and to 0 otherwise, and assert `flag_we_o`. `acc_o` equals `acc_i`.
- R4: For ADD, SUB, INC=7 and DEC=8, `flag_we_o` is 1 and `flag_nx_o` is 1 exactly when the 8-bit result is zero. The result is `acc_o` for ADD and SUB, and `reg_o` for INC and DEC.
- R5: INC and DEC drive `reg_o` with `reg_i`+1 and `reg_i`-1, wrapping modulo 256 (DEC of 0 gives 255). `acc_o` equals `acc_i`. A register counted down from 0 returns to 0 after exactly 256 steps.
- R6: AND, OR, XOR, NOT, MOV=14, CLR=15 and NOP=0 hold `flag_we_o` at 0. After any of them, `flag_o` keeps its value.
- R7: `flag_o` resets to 0. On each rising edge where `flag_we_o` is 1, it takes `flag_nx_o`.
- R8: MOV drives `acc_o` with `opnd_i`. CLR drives `reg_o` with 0. NOP passes `acc_i` and `reg_i` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| op_i | input | 4 | operation code |
| acc_i | input | 8 | current accumulator |
| opnd_i | input | 8 | register value or sign-extended immediate |
| reg_i | input | 8 | current value of the selected register |
| acc_o | output | 8 | new accumulator |
| reg_o | output | 8 | new register value |
| flag_nx_o | output | 1 | proposed flag value |
| flag_we_o | output | 1 | flag write enable |
| flag_o | output | 1 | registered flag F |

## Verification
The bench drives uniformly random operation codes and data, which mixes flag-writing and flag-preserving operations in random orders. This shows whether F is held or overwritten by the right operations. Directed cases cover the points where a signed reading would differ from an unsigned one (0x80 against 0x7F, and an all-ones immediate). They also cover results that land exactly on zero, and equal operands, which separate LT from LE and GT from GE. A 256-step countdown from 0 shows both the wrap of DEC and that the zero flag rises only on the final step.

// File: rtl/acc_alu_flag.sv
module acc_alu_flag #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] reg_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] reg_o,
  output logic         flag_nx_o,
  output logic         flag_we_o,
  output logic         flag_o
);
  localparam logic [3:0] OP_NOP = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2,
    OP_AND = 4'd3, OP_OR = 4'd4, OP_XOR = 4'd5, OP_NOT = 4'd6,
    OP_INC = 4'd7, OP_DEC = 4'd8, OP_EQ = 4'd9, OP_LT = 4'd10,
    OP_LE = 4'd11, OP_GT = 4'd12, OP_GE = 4'd13, OP_MOV = 4'd14,
    OP_CLR = 4'd15;

  logic [W-1:0] sum, diff, rinc, rdec;
  logic         lt, eq;

  assign sum  = acc_i + opnd_i;
  assign diff = acc_i - opnd_i;
  assign rinc = reg_i + 1'b1;
  assign rdec = reg_i - 1'b1;
  assign lt   = acc_i < opnd_i;
  assign eq   = acc_i == opnd_i;

  always_comb begin
    acc_o     = acc_i;
    reg_o     = reg_i;
    flag_nx_o = 1'b0;
    flag_we_o = 1'b0;
    case (op_i)
      OP_ADD: begin acc_o = sum;  flag_we_o = 1'b1; flag_nx_o = ~|sum;  end
      OP_SUB: begin acc_o = diff; flag_we_o = 1'b1; flag_nx_o = ~|diff; end
      OP_AND: acc_o = acc_i & opnd_i;
      OP_OR:  acc_o = acc_i | opnd_i;
      OP_XOR: acc_o = acc_i ^ opnd_i;
      OP_NOT: acc_o = ~acc_i;
      OP_INC: begin reg_o = rinc; flag_we_o = 1'b1; flag_nx_o = ~|rinc; end
      OP_DEC: begin reg_o = rdec; flag_we_o = 1'b1; flag_nx_o = ~|rdec; end
      OP_EQ:  begin flag_we_o = 1'b1; flag_nx_o = eq;        end
      OP_LT:  begin flag_we_o = 1'b1; flag_nx_o = lt;        end
      OP_LE:  begin flag_we_o = 1'b1; flag_nx_o = lt | eq;   end
      OP_GT:  begin flag_we_o = 1'b1; flag_nx_o = ~(lt | eq); end
      OP_GE:  begin flag_we_o = 1'b1; flag_nx_o = ~lt;       end
      OP_MOV: acc_o = opnd_i;
      OP_CLR: reg_o = '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         flag_o <= 1'b0;
    else if (flag_we_o) flag_o <= flag_nx_o;

  // R3
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= OP_EQ && op_i <= OP_GE) |-> (acc_o == acc_i && flag_we_o));
  // R3
  cmp_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LT && acc_i[W-1] && !opnd_i[W-1]) |-> !flag_nx_o);
  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD || op_i == OP_SUB) |-> (flag_nx_o == (acc_o == '0)));
  // R5
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DEC && reg_i == '0) |-> (reg_o == '1 && !flag_nx_o));
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_o |=> $stable(flag_o));
  // R7
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |=> (flag_o == $past(flag_nx_o)));
endmodule

// File: tb/acc_alu_flag_tb.sv
module acc_alu_flag_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] acc_i = '0, opnd_i = '0, reg_i = '0;
  logic [7:0] acc_o, reg_o;
  logic       flag_nx_o, flag_we_o, flag_o;
  int nchk = 0, nerr = 0;
  logic exp_f = 1'b0;

  always #4 clk = ~clk;

  acc_alu_flag u_dut (.clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .reg_i(reg_i), .acc_o(acc_o), .reg_o(reg_o),
    .flag_nx_o(flag_nx_o), .flag_we_o(flag_we_o), .flag_o(flag_o));

  function automatic logic [17:0] model(input logic [3:0] op,
      input logic [7:0] a, input logic [7:0] b, input logic [7:0] r);
    logic [7:0] na = a, nr = r;
    logic we = 1'b0, fv = 1'b0;
    case (op)
      4'd1: begin na = a + b; we = 1; fv = (na == 0); end
      4'd2: begin na = a - b; we = 1; fv = (na == 0); end
      4'd3: na = a & b;
      4'd4: na = a | b;
      4'd5: na = a ^ b;
      4'd6: na = ~a;
      4'd7: begin nr = r + 8'd1; we = 1; fv = (nr == 0); end
      4'd8: begin nr = r - 8'd1; we = 1; fv = (nr == 0); end
      4'd9:  begin we = 1; fv = (a == b); end
      4'd10: begin we = 1; fv = (a < b);  end
      4'd11: begin we = 1; fv = (a <= b); end
      4'd12: begin we = 1; fv = (a > b);  end
      4'd13: begin we = 1; fv = (a >= b); end
      4'd14: na = b;
      4'd15: nr = 8'd0;
      default: ;
    endcase
    return {na, nr, we, fv};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return "R1";
      4'd6: return "R2";
      4'd7, 4'd8: return "R5";
      4'd9, 4'd10, 4'd11, 4'd12, 4'd13: return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] r);
    logic [17:0] m;
    @(negedge clk);
    chk("R7", "flag_o", {7'd0, flag_o}, {7'd0, exp_f});
    op_i = op; acc_i = a; opnd_i = b; reg_i = r;
    m = model(op, a, b, r);
    #1;
    chk(tag_of(op), "acc_o", acc_o, m[17:10]);
    chk(tag_of(op), "reg_o", reg_o, m[9:2]);
    if (m[1]) begin
      chk("R4", "flag_we_o", {7'd0, flag_we_o}, 8'd1);
      chk(tag_of(op) == "R1" || tag_of(op) == "R5" ? "R4" : "R3",
          "flag_nx_o", {7'd0, flag_nx_o}, {7'd0, m[0]});
      exp_f = m[0];
    end else
      chk("R6", "flag_we_o", {7'd0, flag_we_o}, 8'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #10;
    chk("R7", "flag_o reset", {7'd0, flag_o}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    apply(4'd2, 8'd5, 8'd5, 8'd9);      // R4 sub to zero sets F
    apply(4'd3, 8'd0, 8'd0, 8'd0);      // R6 AND keeps F=1
    apply(4'd6, 8'h5A, 8'd0, 8'd3);     // R2
    apply(4'd10, 8'h80, 8'h7F, 8'd0);   // R3 unsigned: 128<127 false
    apply(4'd13, 8'hFF, 8'hFF, 8'd0);   // R3 GE with all-ones immediate
    apply(4'd11, 8'd7, 8'd7, 8'd0);     // R3 LE equal
    apply(4'd12, 8'd7, 8'd7, 8'd0);     // R3 GT equal
    apply(4'd1, 8'hFF, 8'h01, 8'd0);    // R4 add wraps to zero
    apply(4'd14, 8'd1, 8'h33, 8'd0);    // R8 MOV
    apply(4'd15, 8'd1, 8'h33, 8'h44);   // R8 CLR
    apply(4'd0, 8'h12, 8'h34, 8'h56);   // R8 NOP
    apply(4'd8, 8'd0, 8'd0, 8'd0);      // R5 DEC 0 -> 255
    begin
      logic [7:0] cnt = 8'd0;
      for (int i = 0; i < 256; i++) begin
        apply(4'd8, 8'd0, 8'd0, cnt);   // R5 countdown
        cnt = reg_o;
        if (i == 254) chk("R5", "F before last step", {7'd0, flag_nx_o}, 8'd0);
      end
      chk("R5", "count after 256", cnt, 8'd0);
      chk("R5", "F after 256", {7'd0, flag_nx_o}, 8'd1);
    end
    for (int i = 0; i < 3000; i++)
      apply(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    @(negedge clk);
    chk("R7", "flag_o final", {7'd0, flag_o}, {7'd0, exp_f});
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule